// File: doc/BRIEF.md
# Timestamped Event Sample Recorder

This block watches a set of hard-wired signal lanes inside a chip and a write-only software probe register on a small memory-mapped bus. It turns every occurrence into an 80-bit sample: a type code, a timestamp and a parameter word. Each lane has a compare condition that is fixed when the design is built. The condition is a masked equality, and it fires on the cycle it first becomes true. A write to the probe address is an event, and the written 32-bit word becomes its parameter.

Detected events wait in one holding slot per source. A fixed-priority selector moves one slot per cycle into an on-chip circular FIFO. Events from the same cycle therefore leave in a fixed order and all carry the timestamp of that cycle. The timestamp comes from a free-running 32-bit counter. A cycle prescaler advances it once every `TICK_DIV` clocks, which is one microsecond at the nominal clock. A downstream mover pulls samples from the FIFO read port. A sticky flag records that an event was lost.

Top module: `evtrec_top`

## Requirements
- R1: After reset, `fifo_empty` is 1, `overflow` is 0 and `rd_valid` is 0. An event sampled fewer than `TICK_DIV` cycles after reset carries timestamp 0.
- R2: The timestamp of an event equals the number of whole `TICK_DIV`-cycle periods completed between reset release and the clock edge that samples the event.
- R3: A write (`bus_we`=1) with `bus_addr` equal to `PROBE_ADDR` creates one sample of type 0 whose parameter is `bus_wdata`. A write to any other address creates no sample.
- R4: Lane k is bits [k*SIG_W +: SIG_W] of `hw_sig`. It fires on the cycle that (lane & mask_k) == (value_k & mask_k) becomes true after being false. Its sample has type k+1 and the zero-extended lane value as parameter. A condition held true for several cycles gives a single sample.
- R5: A sample read on `rd_data` is laid out as type in [79:64], timestamp in [63:32] and parameter in [31:0].
- R6: Events sampled on the same edge are enqueued on consecutive cycles in ascending type order, and all carry that edge's timestamp.
- R7: Samples leave the FIFO in enqueue order. `DEPTH` (at least 5) back-to-back events are all kept without loss.
- R8: A sample that reaches the FIFO while it holds `DEPTH` entries is dropped and sets `overflow`. `overflow` stays 1 until reset, even after the FIFO is drained.
- R9: An event from a source whose previous sample is still waiting in its holding slot is dropped and sets `overflow`. The waiting sample is kept unchanged.
- R10: `rd_en`=1 while the FIFO is non-empty gives the oldest sample on `rd_data`, with `rd_valid`=1, on the next cycle. `rd_en` while empty leaves `rd_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_sig | input | NUM_HW*SIG_W | Watched signal lanes, one per hardware event |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 32 | Bus write data |
| rd_en | input | 1 | Pop request from the downstream mover |
| rd_valid | output | 1 | `rd_data` holds a popped sample |
| rd_data | output | 80 | Popped sample |
| fifo_empty | output | 1 | FIFO holds no sample |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
The bench fires the probe and every lane in one cycle and checks the order and the shared timestamp. A selector with the wrong priority, or one that restamps at enqueue time, fails this check. A lane condition is held for several cycles, so a level-sensitive detector would flood the FIFO. A lane value that matches only under its mask is used, so a design that ignores the mask would miss it. A lane refires while its slot is still waiting, which exposes a design that overwrites the waiting sample. The FIFO is overfilled and then drained, which catches wrap-pointer errors, lost ordering and an overflow flag that clears itself.

// File: rtl/evtrec_pkg.sv
package evtrec_pkg;
  localparam int TYPE_W   = 16;
  localparam int TS_W     = 32;
  localparam int PAR_W    = 32;
  localparam int SAMPLE_W = TYPE_W + TS_W + PAR_W;

  typedef struct packed {
    logic [TYPE_W-1:0] kind;
    logic [TS_W-1:0]   stamp;
    logic [PAR_W-1:0]  param;
  } sample_t;
endpackage

// File: rtl/evtrec_timebase.sv
module evtrec_timebase
  import evtrec_pkg::*;
#(
  parameter int TICK_DIV = 10
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] stamp
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      stamp <= '0;
    end else if (pre == LAST) begin
      pre   <= '0;
      stamp <= stamp + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pre != LAST) |=> $stable(stamp)); // R2
  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    (pre == LAST) |=> (stamp == $past(stamp) + 1'b1)); // R2
endmodule

// File: rtl/evtrec_capture.sv
module evtrec_capture
  import evtrec_pkg::*;
#(
  parameter int NUM_HW     = 4,
  parameter int SIG_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int PROBE_ADDR = 16,
  parameter logic [NUM_HW*SIG_W-1:0] HW_VALUE = '0,
  parameter logic [NUM_HW*SIG_W-1:0] HW_MASK  = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_HW*SIG_W-1:0] hw_sig,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [PAR_W-1:0]        bus_wdata,
  input  logic [TS_W-1:0]         stamp,
  output logic                    push_valid,
  output sample_t                 push_sample,
  output logic                    collide
);
  localparam int NSLOT = NUM_HW + 1;
  localparam int SELW  = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NUM_HW-1:0] match, prev_match;
  logic [NSLOT-1:0]  fire, pending, grant, accept;
  logic [PAR_W-1:0]  fire_par [NSLOT];
  logic [PAR_W-1:0]  slot_par [NSLOT];
  logic [TS_W-1:0]   slot_ts  [NSLOT];
  logic [SELW-1:0]   sel;

  // slot 0: software probe
  assign fire[0]     = bus_we && (bus_addr == ADDR_W'(PROBE_ADDR));
  assign fire_par[0] = bus_wdata;

  for (genvar k = 0; k < NUM_HW; k++) begin : g_lane
    logic [SIG_W-1:0] lane;
    assign lane          = hw_sig[k*SIG_W +: SIG_W];
    assign match[k]      = ((lane ^ HW_VALUE[k*SIG_W +: SIG_W]) & HW_MASK[k*SIG_W +: SIG_W]) == '0;
    assign fire[k+1]     = match[k] & ~prev_match[k];
    assign fire_par[k+1] = PAR_W'(lane);
  end

  always_ff @(posedge clk) begin
    if (rst) prev_match <= '0;
    else     prev_match <= match;
  end

  // lowest pending slot wins
  always_comb begin
    grant = '0;
    sel   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pending[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        sel = SELW'(i);
      end
    end
  end

  assign accept  = fire & (~pending | grant);
  assign collide = |(fire & pending & ~grant);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)            pending[i] <= 1'b0;
      else if (accept[i]) pending[i] <= 1'b1;
      else if (grant[i])  pending[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (accept[i]) begin
        slot_ts[i]  <= stamp;
        slot_par[i] <= fire_par[i];
      end
    end

    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && !fire[i]) |=> !pending[i]); // R6
    AST_FIRE_HELD: assert property (@(posedge clk) disable iff (rst)
      fire[i] |=> pending[i]); // R4
  end

  assign push_valid        = |pending;
  assign push_sample.kind  = TYPE_W'(sel);
  assign push_sample.stamp = slot_ts[sel];
  assign push_sample.param = slot_par[sel];
endmodule

// File: rtl/evtrec_fifo.sv
module evtrec_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CFULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             full, push_ok, pop_ok;

  assign full    = (count == CFULL);
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = rd_en & ~empty;
  assign drop    = push & full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop_ok;
      if (push_ok) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CFULL); // R7
  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(count) != '0)); // R10
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (full && push && !rd_en) |=> (count == $past(count))); // R8
endmodule

// File: rtl/evtrec_top.sv
module evtrec_top
  import evtrec_pkg::*;
#(
  parameter int NUM_HW     = 4,
  parameter int SIG_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int PROBE_ADDR = 16,
  parameter int DEPTH      = 8,
  parameter int TICK_DIV   = 10,
  parameter logic [NUM_HW*SIG_W-1:0] HW_VALUE = {16'h0004, 16'h0003, 16'h0002, 16'h0001},
  parameter logic [NUM_HW*SIG_W-1:0] HW_MASK  = {16'h00FF, 16'hFFFF, 16'hFFFF, 16'hFFFF}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_HW*SIG_W-1:0] hw_sig,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic                    rd_en,
  output logic                    rd_valid,
  output logic [79:0]             rd_data,
  output logic                    fifo_empty,
  output logic                    overflow
);
  logic [TS_W-1:0] stamp;
  logic            push_valid, collide, drop;
  sample_t         push_sample;

  evtrec_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk(clk), .rst(rst), .stamp(stamp)
  );

  evtrec_capture #(
    .NUM_HW(NUM_HW), .SIG_W(SIG_W), .ADDR_W(ADDR_W), .PROBE_ADDR(PROBE_ADDR),
    .HW_VALUE(HW_VALUE), .HW_MASK(HW_MASK)
  ) u_capture (
    .clk(clk), .rst(rst), .hw_sig(hw_sig), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stamp(stamp), .push_valid(push_valid),
    .push_sample(push_sample), .collide(collide)
  );

  evtrec_fifo #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push_valid), .push_data(push_sample),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .empty(fifo_empty), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (rst)                  overflow <= 1'b0;
    else if (collide || drop) overflow <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (collide || drop) |=> overflow); // R9
endmodule

// File: tb/evtrec_top_bench.sv
module evtrec_top_bench;
  localparam int DIV   = 10;
  localparam int DEPTH = 8;
  localparam logic [7:0] PADDR = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] hw_sig = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid, fifo_empty, overflow;
  logic [79:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [79:0] exp_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  evtrec_top u_evtrec_top (
    .clk(clk), .rst(rst), .hw_sig(hw_sig), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  function automatic logic [79:0] mk(input int t, input int ts, input logic [31:0] p);
    return {16'(t), 32'(ts), p};
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hw_sig = '0; bus_we = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
  endtask

  // drive one bus write on the next edge; expected timestamp from bench cycle count
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == PADDR) exp_q.push_back(mk(0, cyc / DIV, d));
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (8) @(negedge clk);
    for (int g = 0; g < 64; g++) begin
      if (fifo_empty) break;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk({req, " rd_valid"}, 80'(rd_valid), 80'(1));
      if (exp_q.size() == 0) chk({req, " extra sample"}, rd_data, 80'hx);
      else                   chk(req, rd_data, exp_q.pop_front());
    end
    while (exp_q.size() != 0) chk({req, " missing sample"}, 80'h0, exp_q.pop_front());
  endtask

  task automatic t_reset();  // R1
    do_reset();
    chk("R1 empty", 80'(fifo_empty), 80'(1));
    chk("R1 overflow", 80'(overflow), 80'(0));
    chk("R1 rd_valid", 80'(rd_valid), 80'(0));
    repeat (2) @(negedge clk);
    exp_q.push_back(mk(0, 0, 32'h1111_2222));
    bus_we = 1'b1; bus_addr = PADDR; bus_wdata = 32'h1111_2222;
    @(negedge clk); bus_we = 1'b0;
    drain("R1 zero stamp");
  endtask

  task automatic t_probe();  // R3 R5
    bus_write(PADDR, 32'hDEAD_BEEF);
    bus_write(8'h11, 32'h0BAD_0BAD);
    bus_write(8'h00, 32'h0BAD_0001);
    bus_write(PADDR, 32'h0000_0007);
    drain("R3 probe writes");
  endtask

  task automatic t_hw();  // R4
    exp_q.push_back(mk(1, cyc / DIV, 32'h1));
    hw_sig[15:0] = 16'h0001;
    repeat (3) @(negedge clk);
    hw_sig[15:0] = 16'h0000;
    hw_sig[47:32] = 16'h0013;
    hw_sig[63:48] = 16'hAB04;
    exp_q.push_back(mk(4, cyc / DIV, 32'h0000_AB04));
    @(negedge clk);
    hw_sig = '0;
    drain("R4 lane events");
    chk("R4 no overflow", 80'(overflow), 80'(0));
  endtask

  task automatic t_same_cycle();  // R6 R5
    repeat (3) @(negedge clk);
    bus_we = 1'b1; bus_addr = PADDR; bus_wdata = 32'hCAFE_0001;
    hw_sig = {16'h0004, 16'h0003, 16'h0002, 16'h0001};
    exp_q.push_back(mk(0, cyc / DIV, 32'hCAFE_0001));
    for (int k = 1; k <= 4; k++) exp_q.push_back(mk(k, cyc / DIV, 32'(k)));
    @(negedge clk);
    bus_we = 1'b0; hw_sig = '0;
    drain("R6 same-cycle order");
  endtask

  task automatic t_time();  // R2
    bus_write(PADDR, 32'h0000_00A1);
    repeat (7) @(negedge clk);
    bus_write(PADDR, 32'h0000_00A2);
    repeat (13) @(negedge clk);
    bus_write(PADDR, 32'h0000_00A3);
    repeat (250) @(negedge clk);
    bus_write(PADDR, 32'h0000_00A4);
    drain("R2 timestamps");
  endtask

  task automatic t_read_empty();  // R10
    chk("R10 empty before", 80'(fifo_empty), 80'(1));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 rd_valid on empty read", 80'(rd_valid), 80'(0));
    chk("R10 still empty", 80'(fifo_empty), 80'(1));
  endtask

  task automatic t_burst();  // R7
    for (int k = 0; k < DEPTH; k++) bus_write(PADDR, 32'h5000_0000 + 32'(k));
    repeat (3) @(negedge clk);
    chk("R7 no loss flag", 80'(overflow), 80'(0));
    drain("R7 burst order");
  endtask

  task automatic t_overflow();  // R8
    logic [79:0] keep[$];
    for (int k = 0; k < DEPTH + 2; k++) bus_write(PADDR, 32'h7000_0000 + 32'(k));
    for (int k = 0; k < DEPTH; k++) keep.push_back(exp_q[k]);
    exp_q = keep;
    repeat (4) @(negedge clk);
    chk("R8 overflow set", 80'(overflow), 80'(1));
    drain("R8 kept samples");
    chk("R8 overflow sticky", 80'(overflow), 80'(1));
    do_reset();
    chk("R8 overflow cleared by reset", 80'(overflow), 80'(0));
  endtask

  task automatic t_collide();  // R9
    repeat (3) @(negedge clk);
    bus_we = 1'b1; bus_addr = PADDR; bus_wdata = 32'h9999_0000;
    hw_sig = {16'h0004, 16'h0003, 16'h0002, 16'h0001};
    exp_q.push_back(mk(0, cyc / DIV, 32'h9999_0000));
    for (int k = 1; k <= 4; k++) exp_q.push_back(mk(k, cyc / DIV, 32'(k)));
    @(negedge clk);
    bus_we = 1'b0; hw_sig = '0;
    @(negedge clk);
    hw_sig[63:48] = 16'h0004;
    @(negedge clk);
    hw_sig = '0;
    @(negedge clk);
    chk("R9 overflow on refire", 80'(overflow), 80'(1));
    drain("R9 waiting sample kept");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_probe();
    t_hw();
    t_same_cycle();
    t_time();
    t_read_empty();
    t_burst();
    t_overflow();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule